// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Hardware Handshake

This block is an asynchronous serial transceiver modelled on the common 16550 programming style, but reduced in depth. It sends and receives one framing format only: a start bit, eight data bits with the least significant bit first, and one stop bit. It has no parity. Each direction buffers two bytes. One byte sits in a holding register and one in a shift register, so the block has no multi-byte FIFO. A host reaches the block through a three-register interface: data, status and control.

The control register selects one of sixteen bit rates. The same register holds a bit that drives a continuous break on the transmit line. A second bit turns off the CTS/RTS handshake, which is on after reset. The receiver oversamples the line at sixteen times the bit rate. It reports overrun, framing errors and received break conditions in status flags, and a read of the status register clears those flags.

Top module: `serialXcvr`

## Requirements
- R1: After reset, txd is 1, rtsN is 0, the status register (address 1) reads 0x06 and the control register (address 2) reads 0x00.
- R2: A byte written to address 0 is sent on txd with the least significant bit first. The frame is one low start bit, eight data bits and one high stop bit. Each bit lasts 16*BASE_DIV*(rateSel+1) clock cycles.
- R3: The transmitter holds two bytes, one in the shift register and one in the holding register. A write to address 0 while the holding register is full is dropped. Status bit 1 is 1 only while the holding register is empty.
- R4: Control bits [3:0] (rateSel) choose one of sixteen bit rates using the R2 formula. The transmitter and the receiver both use the chosen rate.
- R5: While control bit 4 is 1, txd is held at 0 and no new frame starts.
- R6: While ctsN is 1 and the handshake is on, no new frame starts. A frame that has already started completes normally.
- R7: A received frame with a high stop bit puts its byte in the receive holding register and sets status bit 0. A read of address 0 returns the byte and clears status bit 0.
- R8: If rxd stays low from the start bit through the stop-bit sample, status bit 5 (break) is set and no byte is delivered.
- R9: rtsN is 1 only while the handshake is on, the receive holding register is full and a new frame is being received. Otherwise rtsN is 0.
- R10: If a byte completes while the receive holding register is full, status bit 3 (overrun) is set, the new byte is discarded and the held byte is kept.
- R11: A low stop bit in a frame whose data bits are not all zero sets status bit 4 (framing error), and the byte is still delivered.
- R12: A read of the status register clears status bits 3, 4 and 5.
- R13: When control bit 5 is 1, the handshake is off. ctsN is then ignored and rtsN stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| wrData | input | 8 | Write data from the host |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe; read side effects take place at the clock edge |
| rdData | output | 8 | Read data, a combinational decode of addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ctsN | input | 1 | Clear-to-send from the far end, active low |
| rtsN | output | 1 | Request-to-send to the far end, active low |

## Verification
The embedded assertions check these invariants on every cycle. The transmitter stays idle while ctsN blocks it. A full transmit holding register stays full until its byte moves into the shift register. The receive holding register does not change while it is full. rtsN rises only when a held byte is waiting. The overrun flag clears only after a status read. A break detection never delivers a byte. Only the bench scenarios can show the bit ordering and bit timing on txd at two different rates, and that a byte written while the buffer is full is dropped. They also show that the receiver decodes frames driven on rxd, including the overrun, framing and break cases, and that the flags clear when the status register is read.

// File: rtl/serialXcvrPkg.sv
package serialXcvrPkg;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} txState_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLDLOW} rxState_e;
  typedef enum logic [1:0] {LINE_MARK, LINE_SPACE, LINE_DATA} lineSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     txHoldWr;
    logic     txLoad;
    logic     txShift;
    lineSel_e lineSel;
    logic     rxSample;
    logic     rxCommit;
  } pathStrobe_t;

  typedef struct packed {
    logic breakSeen;
    logic frameErr;
    logic overrun;
    logic txIdle;
    logic txHoldEmpty;
    logic rxFull;
  } status_t;

  // layout matches the control register bits [5:0]
  typedef struct packed {
    logic       flowOff;
    logic       sendBreak;
    logic [3:0] rateSel;
  } ctrlReg_t;

endpackage

// File: rtl/serialXcvrPath.sv
module serialXcvrPath
  import serialXcvrPkg::*;
#(
  parameter int BASE_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        rxd,
  input  logic        ctsN,
  input  pathStrobe_t strobe,
  input  status_t     status,
  output ctrlReg_t    ctrlReg,
  output logic        tick,
  output logic        rxdSync,
  output logic        ctsBlocked,
  output logic        rxShiftZero,
  output logic        txd,
  output logic [7:0]  rdData
);

  localparam int MAX_DIV = BASE_DIV * 16;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [SYNC_STAGES-1:0] rxdPipe, ctsPipe;
  logic [DIV_W-1:0]       divisor, divCnt;
  logic [7:0]             txHold, txShiftReg, rxShiftReg, rxHold;

  // input synchronisers, both lines idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxdPipe <= '1;
      ctsPipe <= '1;
    end else begin
      rxdPipe <= {rxdPipe[SYNC_STAGES-2:0], rxd};
      ctsPipe <= {ctsPipe[SYNC_STAGES-2:0], ctsN};
    end
  end

  assign rxdSync    = rxdPipe[SYNC_STAGES-1];
  assign ctsBlocked = ctsPipe[SYNC_STAGES-1] && !ctrlReg.flowOff;

  // sixteenth-bit tick, period computed from the rate index
  always_comb divisor = DIV_W'(BASE_DIV * (int'(ctrlReg.rateSel) + 1));
  assign tick = (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= divisor - DIV_W'(1);
    else           divCnt <= divCnt - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      txHold     <= '0;
      txShiftReg <= '0;
      rxShiftReg <= '0;
      rxHold     <= '0;
      txd        <= 1'b1;
    end else begin
      if (wrEn && addr == REG_CTRL) ctrlReg <= ctrlReg_t'(wrData[5:0]);
      if (strobe.txHoldWr) txHold <= wrData;
      if (strobe.txLoad)       txShiftReg <= txHold;
      else if (strobe.txShift) txShiftReg <= {1'b0, txShiftReg[7:1]};
      if (strobe.rxSample) rxShiftReg <= {rxdSync, rxShiftReg[7:1]};
      if (strobe.rxCommit) rxHold <= rxShiftReg;
      if (ctrlReg.sendBreak) txd <= 1'b0;
      else begin
        case (strobe.lineSel)
          LINE_SPACE: txd <= 1'b0;
          LINE_DATA:  txd <= txShiftReg[0];
          default:    txd <= 1'b1;
        endcase
      end
    end
  end

  assign rxShiftZero = (rxShiftReg == 8'h00);

  always_comb begin
    case (addr)
      REG_DATA: rdData = rxHold;
      REG_STAT: rdData = {2'b00, status.breakSeen, status.frameErr, status.overrun,
                          status.txIdle, status.txHoldEmpty, status.rxFull};
      REG_CTRL: rdData = {2'b00, ctrlReg};
      default:  rdData = 8'h00;
    endcase
  end

  // R10: a full holding register is never overwritten
  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    status.rxFull |=> $stable(rxHold));

  // R5: a break request pulls the line low on the next cycle
  a_r5_break_low: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg.sendBreak |=> !txd);

endmodule

// File: rtl/serialXcvrCtrl.sv
module serialXcvrCtrl
  import serialXcvrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        tick,
  input  logic        rxdSync,
  input  logic        ctsBlocked,
  input  logic        rxShiftZero,
  input  logic        flowOff,
  input  logic        sendBreak,
  output pathStrobe_t strobe,
  output status_t     status,
  output logic        rtsN
);

  txState_e   txState;
  logic [3:0] txSub;
  logic [2:0] txBit;
  logic       txFull;

  rxState_e   rxState;
  logic [3:0] rxSub;
  logic [2:0] rxBit;
  logic       rxFull, overrunQ, frameErrQ, breakQ;

  logic txLoad, txHoldWr, txBitEnd;
  logic rxMid, rxEnd, stopEval, byteDone, breakHit, framingHit;
  logic statRead, dataRead;

  assign txHoldWr   = wrEn && addr == REG_DATA && !txFull;
  assign txLoad     = tick && txState == TX_IDLE && txFull && !ctsBlocked && !sendBreak;
  assign txBitEnd   = tick && txSub == 4'd15;

  assign rxMid      = tick && rxSub == 4'd7;
  assign rxEnd      = tick && rxSub == 4'd15;
  assign stopEval   = rxState == RX_STOP && rxEnd;
  assign byteDone   = stopEval && (rxdSync || !rxShiftZero);
  assign breakHit   = stopEval && !rxdSync && rxShiftZero;
  assign framingHit = stopEval && !rxdSync && !rxShiftZero;

  assign statRead   = rdEn && addr == REG_STAT;
  assign dataRead   = rdEn && addr == REG_DATA;

  always_comb begin
    strobe.txHoldWr = txHoldWr;
    strobe.txLoad   = txLoad;
    strobe.txShift  = txBitEnd && txState == TX_DATA;
    case (txState)
      TX_START: strobe.lineSel = LINE_SPACE;
      TX_DATA:  strobe.lineSel = LINE_DATA;
      default:  strobe.lineSel = LINE_MARK;
    endcase
    strobe.rxSample = rxEnd && rxState == RX_DATA;
    strobe.rxCommit = byteDone && !rxFull;
  end

  // transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSub   <= '0;
      txBit   <= '0;
      txFull  <= 1'b0;
    end else begin
      if (txLoad)        txFull <= 1'b0;
      else if (txHoldWr) txFull <= 1'b1;
      if (txState == TX_IDLE) begin
        if (txLoad) begin
          txState <= TX_START;
          txSub   <= '0;
        end
      end else if (tick) begin
        if (txSub == 4'd15) begin
          txSub <= '0;
          if (txState == TX_START) begin
            txState <= TX_DATA;
            txBit   <= '0;
          end else if (txState == TX_DATA) begin
            if (txBit == 3'd7) txState <= TX_STOP;
            else               txBit   <= txBit + 3'd1;
          end else begin
            txState <= TX_IDLE;
          end
        end else begin
          txSub <= txSub + 4'd1;
        end
      end
    end
  end

  // receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxBit   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: if (tick && !rxdSync) begin
          rxState <= RX_START;
          rxSub   <= '0;
        end
        RX_START: if (rxMid) begin
          rxSub <= '0;
          if (!rxdSync) begin
            rxState <= RX_DATA;
            rxBit   <= '0;
          end else begin
            rxState <= RX_IDLE;
          end
        end else if (tick) rxSub <= rxSub + 4'd1;
        RX_DATA: if (rxEnd) begin
          rxSub <= '0;
          if (rxBit == 3'd7) rxState <= RX_STOP;
          else               rxBit   <= rxBit + 3'd1;
        end else if (tick) rxSub <= rxSub + 4'd1;
        RX_STOP: if (rxEnd) begin
          rxSub   <= '0;
          rxState <= rxdSync ? RX_IDLE : RX_HOLDLOW;
        end else if (tick) rxSub <= rxSub + 4'd1;
        default: if (rxdSync) rxState <= RX_IDLE;
      endcase
    end
  end

  // receive buffer state and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      overrunQ  <= 1'b0;
      frameErrQ <= 1'b0;
      breakQ    <= 1'b0;
    end else begin
      if (strobe.rxCommit) rxFull <= 1'b1;
      else if (dataRead)   rxFull <= 1'b0;
      overrunQ  <= (byteDone && rxFull) || (overrunQ && !statRead);
      frameErrQ <= framingHit || (frameErrQ && !statRead);
      breakQ    <= breakHit || (breakQ && !statRead);
    end
  end

  assign rtsN = !flowOff && rxFull && rxState != RX_IDLE;

  always_comb begin
    status.rxFull      = rxFull;
    status.txHoldEmpty = !txFull;
    status.txIdle      = txState == TX_IDLE && !txFull;
    status.overrun     = overrunQ;
    status.frameErr    = frameErrQ;
    status.breakSeen   = breakQ;
  end

  // R6: a blocked transmitter stays idle
  a_r6_hold_when_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && ctsBlocked) |=> txState == TX_IDLE);

  // R3: a filled holding register keeps its byte until it is loaded
  a_r3_full_until_load: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && !txLoad) |=> txFull);

  // R12: the overrun flag drops only after a status read
  a_r12_overrun_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrunQ) |-> $past(statRead));

  // R8: a detected break never hands a byte to the holding register
  a_r8_break_no_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakQ) |-> $past(!strobe.rxCommit));

endmodule

// File: rtl/serialXcvr.sv
module serialXcvr
  import serialXcvrPkg::*;
#(
  parameter int BASE_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       rxd,
  output logic       txd,
  input  logic       ctsN,
  output logic       rtsN
);

  pathStrobe_t strobeW;
  status_t     statusW;
  ctrlReg_t    ctrlRegW;
  logic        tickW, rxdSyncW, ctsBlockedW, rxShiftZeroW;

  serialXcvrCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .tick       (tickW),
    .rxdSync    (rxdSyncW),
    .ctsBlocked (ctsBlockedW),
    .rxShiftZero(rxShiftZeroW),
    .flowOff    (ctrlRegW.flowOff),
    .sendBreak  (ctrlRegW.sendBreak),
    .strobe     (strobeW),
    .status     (statusW),
    .rtsN       (rtsN)
  );

  serialXcvrPath #(
    .BASE_DIV   (BASE_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .wrData     (wrData),
    .wrEn       (wrEn),
    .rxd        (rxd),
    .ctsN       (ctsN),
    .strobe     (strobeW),
    .status     (statusW),
    .ctrlReg    (ctrlRegW),
    .tick       (tickW),
    .rxdSync    (rxdSyncW),
    .ctsBlocked (ctsBlockedW),
    .rxShiftZero(rxShiftZeroW),
    .txd        (txd),
    .rdData     (rdData)
  );

  // R9: request-to-send is withdrawn only with a byte waiting
  a_r9_rts_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    rtsN |-> statusW.rxFull);

endmodule

// File: tb/serialXcvr_tb.sv
module serialXcvr_tb;

  localparam int BASE_DIV = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic       rxd = 1'b1, ctsN = 1'b0;
  logic       txd, rtsN;

  int checks = 0, errors = 0;
  int framesSeen = 0;
  int bitClkCur = 16 * BASE_DIV;
  bit breakMode = 1'b0;
  logic [7:0] txExp[$];

  always #2 clk = ~clk;

  serialXcvr #(.BASE_DIV(BASE_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .rxd(rxd), .txd(txd), .ctsN(ctsN), .rtsN(rtsN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    txExp.push_back(d);
    busWrite(2'd0, d);
  endtask

  task automatic waitFrames(input int target, input string tag);
    for (int i = 0; i < 4000 && framesSeen < target; i++) @(negedge clk);
    check(framesSeen == target, tag, framesSeen, target);
  endtask

  task automatic waitHoldEmpty();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      busRead(2'd1, s);
      if (s[1]) break;
    end
  endtask

  task automatic sendRx(input logic [7:0] d, input logic stopV);
    @(negedge clk); rxd = 1'b0;
    repeat (bitClkCur) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitClkCur) @(negedge clk);
    end
    rxd = stopV;
    repeat (bitClkCur) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: decodes txd and compares with the queue
  initial begin
    logic prevTx;
    logic [7:0] got, exp;
    logic startV, stopV;
    int bc;
    prevTx = 1'b1;
    forever begin
      @(negedge clk);
      if (!breakMode && prevTx === 1'b1 && txd === 1'b0) begin
        bc = bitClkCur;
        repeat (bc / 2) @(negedge clk);
        startV = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = txd;
        end
        repeat (bc) @(negedge clk);
        stopV = txd;
        if (txExp.size() == 0) check(1'b0, "R2 unexpected frame", got, 0);
        else begin
          exp = txExp.pop_front();
          check(got == exp && startV == 1'b0 && stopV == 1'b1,
                "R2 frame content", {startV, got, stopV}, {1'b0, exp, 1'b1});
        end
        framesSeen++;
      end
      prevTx = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int fs;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(rtsN == 1'b0, "R1 rtsN", rtsN, 0);
    busRead(2'd1, r); check(r == 8'h06, "R1 status", r, 8'h06);
    busRead(2'd2, r); check(r == 8'h00, "R1 control", r, 8'h00);

    // R2 single frame at rate 0
    pushTx(8'hA5);
    waitFrames(1, "R2 one frame");

    // R3 two-byte buffering, third write dropped
    pushTx(8'h3C);
    waitHoldEmpty();
    pushTx(8'hC3);
    busWrite(2'd0, 8'h77);
    busRead(2'd1, r); check(r[1] == 1'b0, "R3 hold full", r[1], 0);
    waitFrames(3, "R3 two frames");
    repeat (800) @(negedge clk);
    check(framesSeen == 3, "R3 dropped write", framesSeen, 3);

    // R4 rate 2
    busWrite(2'd2, 8'h02);
    bitClkCur = 16 * BASE_DIV * 3;
    pushTx(8'h5A);
    waitFrames(4, "R4 rate 2 frame");
    busWrite(2'd2, 8'h00);
    bitClkCur = 16 * BASE_DIV;
    repeat (20) @(negedge clk);

    // R6 blocked start
    ctsN = 1'b1;
    repeat (10) @(negedge clk);
    pushTx(8'h81);
    repeat (700) @(negedge clk);
    check(framesSeen == 4, "R6 no start while blocked", framesSeen, 4);
    busRead(2'd1, r); check(r[1] == 1'b0, "R6 byte still held", r[1], 0);
    ctsN = 1'b0;
    waitFrames(5, "R6 start after release");

    // R6 frame in progress completes, next waits
    pushTx(8'h42);
    for (int i = 0; i < 500 && txd !== 1'b0; i++) @(negedge clk);
    repeat (50) @(negedge clk);
    ctsN = 1'b1;
    waitHoldEmpty();
    pushTx(8'h24);
    waitFrames(6, "R6 running frame completes");
    repeat (400) @(negedge clk);
    check(framesSeen == 6, "R6 second byte waits", framesSeen, 6);
    ctsN = 1'b0;
    waitFrames(7, "R6 second byte after release");

    // R13 handshake off
    ctsN = 1'b1;
    busWrite(2'd2, 8'h20);
    pushTx(8'h99);
    waitFrames(8, "R13 ignores ctsN");

    // R5 break send
    breakMode = 1'b1;
    busWrite(2'd2, 8'h10);
    repeat (3) @(negedge clk);
    check(txd == 1'b0, "R5 break start", txd, 0);
    repeat (200) @(negedge clk);
    check(txd == 1'b0, "R5 break held", txd, 0);
    busWrite(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R5 break released", txd, 1);
    breakMode = 1'b0;
    ctsN = 1'b0;
    repeat (20) @(negedge clk);

    // R7 receive, R9 rts stays asserted with empty hold
    fork
      sendRx(8'h6E, 1'b1);
      begin
        repeat (bitClkCur * 3) @(negedge clk);
        check(rtsN == 1'b0, "R9 rts with empty hold", rtsN, 0);
      end
    join
    busRead(2'd1, r); check(r[0] == 1'b1, "R7 rx full", r[0], 1);
    busRead(2'd0, r); check(r == 8'h6E, "R7 rx byte", r, 8'h6E);
    busRead(2'd1, r); check(r[0] == 1'b0, "R7 rx cleared", r[0], 0);

    // R9 / R10 overrun
    sendRx(8'h11, 1'b1);
    fork
      sendRx(8'h22, 1'b1);
      begin
        repeat (bitClkCur * 3) @(negedge clk);
        check(rtsN == 1'b1, "R9 rts withdrawn", rtsN, 1);
      end
    join
    busRead(2'd1, r); check(r[3] == 1'b1, "R10 overrun flag", r[3], 1);
    busRead(2'd0, r); check(r == 8'h11, "R10 held byte kept", r, 8'h11);
    busRead(2'd1, r); check(r[3] == 1'b0, "R12 overrun cleared", r[3], 0);
    check(rtsN == 1'b0, "R9 rts restored", rtsN, 0);

    // R11 framing error
    sendRx(8'h3F, 1'b0);
    busRead(2'd1, r); check(r[5:3] == 3'b010 && r[0], "R11 framing flag", r, 8'h11);
    busRead(2'd0, r); check(r == 8'h3F, "R11 byte delivered", r, 8'h3F);
    busRead(2'd1, r); check(r[4] == 1'b0, "R12 framing cleared", r[4], 0);

    // R8 break detect
    @(negedge clk); rxd = 1'b0;
    repeat (bitClkCur * 12) @(negedge clk);
    rxd = 1'b1;
    repeat (bitClkCur) @(negedge clk);
    busRead(2'd1, r); check(r[5] == 1'b1 && r[0] == 1'b0, "R8 break flag, no byte", r, 8'h26);
    busRead(2'd1, r); check(r[5] == 1'b0, "R12 break cleared", r[5], 0);

    fs = framesSeen;
    check(fs == 8 && txExp.size() == 0, "R2 scoreboard drained", txExp.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule